// File: doc/BRIEF.md
# Memory-Mapped GPIO Controller with Edge Interrupts

This block drives and samples 32 general-purpose pins. Software reaches it through a simple register bus with one-cycle access. A write takes effect at the clock edge where the strobe is high. Read data is combinational while the read strobe is high and is zero otherwise.

For each pin, software selects the direction, push-pull or open-drain drive, and the output value. It can also read back the pin level. Pad inputs pass through a two-flop synchroniser. An edge detector compares each synchronised level with its value one cycle earlier.

Edges that the selected sense setting allows latch into a sticky event register. Software clears event bits by writing ones to them. A mask register gates the events onto one combined interrupt line.

The parameter `TWO_BIT_SENSE` selects the sense scheme:
- 0: one control bit per pin, choosing falling edge only or any edge.
- 1: a two-bit field per pin, choosing falling, rising or any edge. The fields are split across two control registers.

Pad buffers, bus bridging and the upstream interrupt controller sit outside the block.

Top module: `gpio_ctrl`

## Requirements
- R1: After reset every register reads zero, `pad_oe` and `pad_out` are all zero and `irq` is low.
- R2: Byte offsets on `bus_addr` are fixed: direction 0x00, open-drain 0x04, data 0x08, event 0x0C, mask 0x10, sense control A 0x14, sense control B 0x18. Pin n maps to bit 31−n of every per-pin register and of `pad_in`, `pad_out` and `pad_oe`.
- R3: A direction bit of 1 makes the pin an output: push-pull output pins drive `pad_oe`=1 with `pad_out` equal to the output latch. Input pins (direction 0) have `pad_oe`=0.
- R4: An output pin with its open-drain bit set releases the pad (`pad_oe`=0) when its latch is 1. When its latch is 0 it drives `pad_oe`=1 with `pad_out`=0.
- R5: Reading the data register returns the output latch for output pins. For input pins it returns `pad_in` after two clock edges of synchronisation.
- R6: Event bits are sticky. Writing 1 to an event bit clears it; writing 0 leaves it unchanged.
- R7: When an edge and a clear hit the same event bit at the same edge, the bit stays set. Events latch whatever the mask holds.
- R8: `irq` is high exactly when some event bit and the matching mask bit (1 = enabled) are both 1.
- R9: With `TWO_BIT_SENSE`=0, a control A bit of 1 latches only falling edges and 0 latches both edges. Register 0x18 then reads zero and ignores writes.
- R10: With `TWO_BIT_SENSE`=1, pins 0–15 take their field from control A and pins 16–31 from control B. The field sits at bits [(15−(n mod 16))×2 +: 2]. 2'b10 selects falling only, 2'b01 rising only, and 2'b00 or 2'b11 both edges.
- R11: A change on `pad_in` sets its event bit at the third rising clock edge after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 5 | Byte offset of the register accessed |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero when `bus_rd` is low |
| pad_in | input | 32 | Pad levels, pin n at bit 31−n |
| pad_out | output | 32 | Pad output values |
| pad_oe | output | 32 | Pad output enables |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions assume the following about the inputs:
- `bus_addr` is stable and meaningful whenever a strobe is high.
- Reset is held long enough for the internal reset synchroniser to settle.

The stimulus changes all inputs only at falling clock edges. Random pad changes are spaced at least four cycles apart, so each edge has fully latched before the next one arrives. A single deliberately aligned case makes a pad edge and a write-one-to-clear land on the same rising edge. Two instances share the same stimulus, one for each sense scheme, so both encodings see identical edges.

// File: rtl/gpio_ctrl_pkg.sv
package gpio_ctrl_pkg;
  localparam int unsigned NPINS  = 32;
  localparam int unsigned ADDR_W = 5;

  localparam logic [ADDR_W-1:0] OFS_DIR  = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_ODRN = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_DATA = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_EVT  = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_MASK = 5'h10;
  localparam logic [ADDR_W-1:0] OFS_SNSA = 5'h14;
  localparam logic [ADDR_W-1:0] OFS_SNSB = 5'h18;

  typedef enum logic [1:0] {
    SNS_ANY  = 2'b00,
    SNS_RISE = 2'b01,
    SNS_FALL = 2'b10,
    SNS_ANY2 = 2'b11
  } sense_fld_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] lvl_now,
  output logic [W-1:0] lvl_prev
);
  logic [W-1:0] meta_q, meta_d;
  logic [W-1:0] now_q, now_d;
  logic [W-1:0] prev_q, prev_d;

  always_comb begin
    meta_d = pad_in;
    now_d  = meta_q;
    prev_d = now_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      now_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= meta_d;
      now_q  <= now_d;
      prev_q <= prev_d;
    end
  end

  assign lvl_now  = now_q;
  assign lvl_prev = prev_q;
endmodule

// File: rtl/gpio_edge_sense.sv
module gpio_edge_sense
  import gpio_ctrl_pkg::*;
#(
  parameter int unsigned W             = 32,
  parameter bit          TWO_BIT_SENSE = 1'b1
) (
  input  logic [W-1:0] lvl_now,
  input  logic [W-1:0] lvl_prev,
  input  logic [W-1:0] sns_a,
  input  logic [W-1:0] sns_b,
  output logic [W-1:0] edge_hit
);
  localparam int unsigned HALF = W / 2;

  logic [W-1:0] rise, fall;
  assign rise = lvl_now & ~lvl_prev;
  assign fall = ~lvl_now & lvl_prev;

  for (genvar b = 0; b < W; b++) begin : g_bit
    if (TWO_BIT_SENSE) begin : g_two
      // Register bit b holds pin W-1-b. Pins in the first half (bits at the
      // top) use control A, the rest use control B.
      logic [1:0] fld;
      if (b >= HALF) begin : g_a
        assign fld = sns_a[(b-HALF)*2 +: 2];
      end else begin : g_b
        assign fld = sns_b[b*2 +: 2];
      end
      assign edge_hit[b] = (rise[b] && (fld != SNS_FALL)) ||
                           (fall[b] && (fld != SNS_RISE));
    end else begin : g_one
      assign edge_hit[b] = fall[b] || (rise[b] && !sns_a[b]);
    end
  end

  if (!TWO_BIT_SENSE) begin : g_unused_b
    logic unused_b;
    assign unused_b = ^sns_b;
  end
endmodule

// File: rtl/gpio_event_reg.sv
module gpio_event_reg #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] edge_hit,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] evt_q
);
  logic [W-1:0] evt_d;
  logic         evt_en;

  always_comb begin
    evt_en = (|edge_hit) || (|clr_mask);
    evt_d  = (evt_q & ~clr_mask) | edge_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      evt_q <= '0;
    else if (evt_en) evt_q <= evt_d;
  end

  p_w1c_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((evt_q & $past(clr_mask & ~edge_hit)) == '0));

  p_edge_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((evt_q & $past(edge_hit)) == $past(edge_hit)));

  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(evt_q) & ~$past(clr_mask)) & ~evt_q) == '0));
endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_ctrl_pkg::*;
#(
  parameter bit TWO_BIT_SENSE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [NPINS-1:0]  bus_wdata,
  output logic [NPINS-1:0]  bus_rdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe,
  output logic              irq
);
  localparam int unsigned W = NPINS;

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end
  logic rstn_i;
  assign rstn_i = rst_sync_q;

  logic wr_dir, wr_odrn, wr_data, wr_evt, wr_mask, wr_snsa, wr_snsb;
  always_comb begin
    wr_dir  = bus_wr && (bus_addr == OFS_DIR);
    wr_odrn = bus_wr && (bus_addr == OFS_ODRN);
    wr_data = bus_wr && (bus_addr == OFS_DATA);
    wr_evt  = bus_wr && (bus_addr == OFS_EVT);
    wr_mask = bus_wr && (bus_addr == OFS_MASK);
    wr_snsa = bus_wr && (bus_addr == OFS_SNSA);
    wr_snsb = bus_wr && (bus_addr == OFS_SNSB);
  end

  logic [W-1:0] dir_q, odrn_q, lat_q, mask_q, snsa_q, snsb_q;
  logic [W-1:0] dir_d, odrn_d, lat_d, mask_d, snsa_d;

  always_comb begin
    dir_d  = bus_wdata;
    odrn_d = bus_wdata;
    lat_d  = bus_wdata;
    mask_d = bus_wdata;
    snsa_d = bus_wdata;
  end

  always_ff @(posedge clk or negedge rstn_i) begin
    if (!rstn_i) begin
      dir_q  <= '0;
      odrn_q <= '0;
      lat_q  <= '0;
      mask_q <= '0;
      snsa_q <= '0;
    end else begin
      if (wr_dir)  dir_q  <= dir_d;
      if (wr_odrn) odrn_q <= odrn_d;
      if (wr_data) lat_q  <= lat_d;
      if (wr_mask) mask_q <= mask_d;
      if (wr_snsa) snsa_q <= snsa_d;
    end
  end

  if (TWO_BIT_SENSE) begin : g_snsb
    logic [W-1:0] snsb_d;
    always_comb snsb_d = bus_wdata;
    always_ff @(posedge clk or negedge rstn_i) begin
      if (!rstn_i)      snsb_q <= '0;
      else if (wr_snsb) snsb_q <= snsb_d;
    end
  end else begin : g_no_snsb
    assign snsb_q = '0;
    logic unused_wr_snsb;
    assign unused_wr_snsb = wr_snsb;
  end

  logic [W-1:0] lvl_now, lvl_prev, edge_hit, evt_q, clr_mask;

  gpio_in_sync #(.W(W)) i_sync (
    .clk      (clk),
    .rst_n    (rstn_i),
    .pad_in   (pad_in),
    .lvl_now  (lvl_now),
    .lvl_prev (lvl_prev)
  );

  gpio_edge_sense #(.W(W), .TWO_BIT_SENSE(TWO_BIT_SENSE)) i_sense (
    .lvl_now  (lvl_now),
    .lvl_prev (lvl_prev),
    .sns_a    (snsa_q),
    .sns_b    (snsb_q),
    .edge_hit (edge_hit)
  );

  assign clr_mask = wr_evt ? bus_wdata : '0;

  gpio_event_reg #(.W(W)) i_evt (
    .clk      (clk),
    .rst_n    (rstn_i),
    .edge_hit (edge_hit),
    .clr_mask (clr_mask),
    .evt_q    (evt_q)
  );

  // pad drive: open-drain pins only ever drive low
  assign pad_oe  = dir_q & ~(odrn_q & lat_q);
  assign pad_out = lat_q & ~odrn_q;
  assign irq     = |(evt_q & mask_q);

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      unique case (bus_addr)
        OFS_DIR:  bus_rdata = dir_q;
        OFS_ODRN: bus_rdata = odrn_q;
        OFS_DATA: bus_rdata = (dir_q & lat_q) | (~dir_q & lvl_now);
        OFS_EVT:  bus_rdata = evt_q;
        OFS_MASK: bus_rdata = mask_q;
        OFS_SNSA: bus_rdata = snsa_q;
        OFS_SNSB: bus_rdata = snsb_q;
        default:  bus_rdata = '0;
      endcase
    end
  end

  p_input_no_drive_r3: assert property (@(posedge clk) disable iff (!rstn_i)
    (pad_oe & ~dir_q) == '0);

  p_od_release_r4: assert property (@(posedge clk) disable iff (!rstn_i)
    (pad_oe & odrn_q & lat_q) == '0);

  p_irq_needs_event_r8: assert property (@(posedge clk) disable iff (!rstn_i)
    irq |-> ((evt_q != '0) && (mask_q != '0)));

  p_evt_needs_change_r11: assert property (@(posedge clk) disable iff (!rstn_i)
    1'b1 |=> ((evt_q & ~$past(evt_q) & ~$past(lvl_now ^ lvl_prev)) == '0));
endmodule

// File: tb/test_gpio_ctrl.sv
`timescale 1ns/1ps
module test_gpio_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  bus_addr;
  logic        bus_wr, bus_rd;
  logic [31:0] bus_wdata, pad_in;
  logic [31:0] rdata2, rdata1, pout2, pout1, poe2, poe1;
  logic        irq2, irq1;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gpio_ctrl #(.TWO_BIT_SENSE(1'b1)) i_gpio_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(rdata2),
    .pad_in(pad_in), .pad_out(pout2), .pad_oe(poe2), .irq(irq2));

  gpio_ctrl #(.TWO_BIT_SENSE(1'b0)) i_gpio_ctrl_1b (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(rdata1),
    .pad_in(pad_in), .pad_out(pout1), .pad_oe(poe1), .irq(irq1));

  // bench model of software-visible state
  logic [31:0] m_dir, m_od, m_lat, m_mask, m_sa, m_sb, m_ev2, m_ev1;

  function automatic logic [31:0] edges(input bit two, input logic [31:0] oldv,
      input logic [31:0] newv, input logic [31:0] sa, input logic [31:0] sb);
    logic [31:0] r = '0;
    for (int n = 0; n < 32; n++) begin
      int b = 31 - n;
      logic up = newv[b] & ~oldv[b];
      logic dn = ~newv[b] & oldv[b];
      logic [1:0] f;
      if (two) begin
        f = (n < 16) ? sa[(15 - n)*2 +: 2] : sb[(15 - (n - 16))*2 +: 2];
        r[b] = (up && f != 2'b10) || (dn && f != 2'b01);
      end else begin
        r[b] = dn || (up && !sa[b]);
      end
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d2, output logic [31:0] d1);
    bus_addr = a; bus_rd = 1'b1;
    #1;
    d2 = rdata2; d1 = rdata1;
    bus_rd = 1'b0;
  endtask

  task automatic set_pads(input logic [31:0] v);
    logic [31:0] old = pad_in;
    @(negedge clk);
    pad_in = v;
    m_ev2 |= edges(1'b1, old, v, m_sa, m_sb);
    m_ev1 |= edges(1'b0, old, v, m_sa, m_sb);
    repeat (4) @(negedge clk);
  endtask

  task automatic check_all(input string note);
    logic [31:0] a2, a1;
    rd(5'h0C, a2, a1);
    chk({"R6 R11 event 2b ", note}, a2, m_ev2);
    chk({"R9 event 1b ", note}, a1, m_ev1);
    chk({"R8 irq 2b ", note}, {31'd0, irq2}, {31'd0, |(m_ev2 & m_mask)});
    chk({"R8 irq 1b ", note}, {31'd0, irq1}, {31'd0, |(m_ev1 & m_mask)});
    rd(5'h08, a2, a1);
    chk({"R5 data ", note}, a2, (m_dir & m_lat) | (~m_dir & pad_in));
    chk({"R3 R4 oe ", note}, poe2, m_dir & ~(m_od & m_lat));
    chk({"R3 R4 out ", note}, pout2, m_lat & ~m_od);
  endtask

  task automatic wr_all(input logic [31:0] d, o, l, m, sa, sb);
    wr(5'h00, d); wr(5'h04, o); wr(5'h08, l); wr(5'h10, m);
    wr(5'h14, sa); wr(5'h18, sb);
    m_dir = d; m_od = o; m_lat = l; m_mask = m; m_sa = sa; m_sb = sb;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] a2, a1, p;
    void'($urandom(32'd1234));
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0;
    bus_wdata = '0; pad_in = '0;
    m_dir = '0; m_od = '0; m_lat = '0; m_mask = '0; m_sa = '0; m_sb = '0;
    m_ev2 = '0; m_ev1 = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int k = 0; k < 7; k++) begin
      rd(5'(k*4), a2, a1);
      chk("R1 reset reg", a2, 32'h0);
    end
    chk("R1 reset oe", poe2, 32'h0);
    chk("R1 reset out", pout2, 32'h0);
    chk("R1 reset irq", {31'd0, irq2}, 32'h0);

    // R2 mapping: pin 0 at bit 31 on the pad vectors
    wr_all(32'h8000_0001, 32'h0, 32'h8000_0000, 32'h0, 32'h0, 32'h0);
    chk("R2 pin0 oe bit31", poe2, 32'h8000_0001);
    chk("R2 pin0 out bit31", pout2, 32'h8000_0000);
    rd(5'h10, a2, a1);
    chk("R2 mask offset", a2, 32'h0);

    // R4 open drain directed
    wr(5'h04, 32'h0000_0003); m_od = 32'h3;
    wr(5'h00, 32'h0000_0003); m_dir = 32'h3;
    wr(5'h08, 32'h0000_0001); m_lat = 32'h1;
    chk("R4 od latch1 released", poe2, 32'h0000_0002);
    chk("R4 od out low", pout2, 32'h0);

    // R11 timing and R7 mask independence
    wr_all(32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0);
    @(negedge clk); pad_in = 32'h0400_0000;
    @(negedge clk); @(negedge clk);
    rd(5'h0C, a2, a1);
    chk("R11 not yet after two edges", a2, 32'h0);
    @(negedge clk);
    rd(5'h0C, a2, a1);
    chk("R11 set at third edge", a2, 32'h0400_0000);
    chk("R7 latched while masked irq low", {31'd0, irq2}, 32'h0);
    wr(5'h10, 32'h0400_0000);
    chk("R8 irq after unmask", {31'd0, irq2}, 32'h1);

    // R6 write zero no effect, write one clears
    wr(5'h0C, 32'h0);
    rd(5'h0C, a2, a1);
    chk("R6 write zero keeps", a2, 32'h0400_0000);
    wr(5'h0C, 32'hFFFF_FFFF);
    rd(5'h0C, a2, a1);
    chk("R6 write one clears", a2, 32'h0);
    chk("R8 irq drops", {31'd0, irq2}, 32'h0);

    // R7 edge and clear at the same edge
    @(negedge clk); pad_in = 32'h0410_0000;
    repeat (4) @(negedge clk);
    @(negedge clk); pad_in = 32'h0010_0000;   // pin 5 falls again
    @(negedge clk); @(negedge clk);
    bus_addr = 5'h0C; bus_wdata = 32'h0410_0000; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
    rd(5'h0C, a2, a1);
    chk("R7 edge wins over clear", a2, 32'h0400_0000);
    wr(5'h0C, 32'hFFFF_FFFF);
    wr(5'h10, 32'h0); m_mask = '0;
    p = 32'h0; @(negedge clk); pad_in = p;
    repeat (4) @(negedge clk);
    wr(5'h0C, 32'hFFFF_FFFF);
    m_ev2 = '0; m_ev1 = '0;

    // R10 / R9 directed sense fields
    wr_all(32'h0, 32'h0, 32'h0, 32'h0, 32'h9000_0000, 32'h4000_0000);
    rd(5'h18, a2, a1);
    chk("R9 ctrl B reads zero in 1b", a1, 32'h0);
    chk("R10 ctrl B kept in 2b", a2, 32'h4000_0000);
    set_pads(32'hC000_8000);
    rd(5'h0C, a2, a1);
    chk("R10 rise fields", a2, 32'h4000_8000);
    chk("R9 rise 1b", a1, 32'h4000_8000);
    wr(5'h0C, 32'hFFFF_FFFF); m_ev2 = '0; m_ev1 = '0;
    set_pads(32'h0);
    rd(5'h0C, a2, a1);
    chk("R10 fall fields", a2, 32'h8000_0000);
    chk("R9 fall 1b", a1, 32'hC000_8000);
    wr(5'h0C, 32'hFFFF_FFFF); m_ev2 = '0; m_ev1 = '0;

    // constrained random
    for (int it = 0; it < 60; it++) begin
      wr_all($urandom, $urandom, $urandom, $urandom, $urandom, $urandom);
      wr(5'h0C, 32'hFFFF_FFFF); m_ev2 = '0; m_ev1 = '0;
      check_all("after clear");
      set_pads($urandom);
      check_all("after edges");
      p = $urandom;
      wr(5'h0C, p); m_ev2 &= ~p; m_ev1 &= ~p;
      check_all("partial clear");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule